// File: doc/BRIEF.md
# Packed BCD Byte Adder-Subtractor

This block adds or subtracts two packed decimal bytes, each holding two BCD digits, and folds in the extend flag as a decimal carry-in or borrow-in. It is the datapath behind decimal add and decimal subtract instructions. The caller supplies the two operands and the current extend and zero flags, and raises `in_valid` for one cycle per operation. The block returns the decimal-adjusted byte, one carry/borrow bit and the updated zero flag. The carry/borrow bit is meant to load both the carry and the extend flags.

Correction is not done digit-serially. The block first forms the plain binary sum or difference of the low nibbles to decide whether the units digit needs a correction of six. It then forms the whole byte result with that correction and tests it against a threshold to decide on the tens correction of 0x60, which also gives the carry or borrow. All outputs come from one register stage, so a result appears on the cycle after the operation is presented.

Top module: `bcd_byte_addsub`

## Requirements
- R1: Addition (`op_sub`=0): when acc_in[3:0] + opd_in[3:0] + x_in is 10 or more, 6 is added to the byte sum before the tens check.
- R2: Addition: when the byte sum after the units correction is 0xA0 or more, 0x60 is added, `result` takes the low 8 bits and `cx_out` is 1; otherwise `cx_out` is 0.
- R3: Addition: `x_in`=1 adds one to the units digit as a carry-in.
- R4: Subtraction (`op_sub`=1, result = acc_in - opd_in - x_in): when acc_in[3:0] - opd_in[3:0] - x_in is negative, 6 is subtracted from the byte difference.
- R5: Subtraction: when the byte difference after the units correction is negative, 0x60 is subtracted, `result` takes the low 8 bits of the two's-complement value and `cx_out` is 1 (borrow); otherwise `cx_out` is 0.
- R6: Subtraction: `x_in`=1 is subtracted as a borrow-in from the units digit.
- R7: `z_out` is 0 when the result byte is non-zero. When the result byte is zero, `z_out` equals the `z_in` presented with the operation.
- R8: Outputs are registered. `res_valid` is 1 exactly on the cycle after a cycle with `in_valid`=1. While `in_valid` is 0, `result`, `cx_out` and `z_out` hold their values.
- R9: Synchronous active-high reset clears `res_valid`, `result`, `cx_out` and `z_out` to 0.
- R10: When both operands are valid BCD (each nibble 9 or less), both nibbles of `result` are valid BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| op_sub | input | 1 | 0 = decimal add, 1 = decimal subtract |
| acc_in | input | 8 | Destination operand (augend or minuend), two BCD digits |
| opd_in | input | 8 | Source operand (addend or subtrahend), two BCD digits |
| x_in | input | 1 | Incoming extend flag (carry-in or borrow-in) |
| z_in | input | 1 | Incoming zero flag |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 8 | Decimal-adjusted result byte |
| cx_out | output | 1 | Decimal carry or borrow, for both carry and extend flags |
| z_out | output | 1 | Updated zero flag |

## Verification
The hardest cases are the ones where the two corrections interact. One is a units correction that by itself pushes the byte over the tens threshold, as in 0x45 + 0x54 with carry-in, which wraps to exactly zero with a carry. Another is a borrow-in that drives the units digit to minus ten while the tens digit stays non-negative, as in 0x50 - 0x49 - 1. These sums come about only through particular operand pairs. The vector table includes them on purpose, each with `z_in`=1, so a zero result can show that the zero flag is held and not set. Hold behaviour is checked by changing operands while `in_valid` is low.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  // digit and byte geometry
  localparam int NIB_W  = 4;
  localparam int NDIG   = 2;
  localparam int BYTE_W = NIB_W * NDIG;
  // wide enough for sum of two bytes plus carry and correction, with sign
  localparam int WIDE_W = BYTE_W + 2;
  localparam int LO_W   = NIB_W + 2;

  // decimal correction constants
  localparam int DEC_BASE  = 10;
  localparam int LO_ADJ    = 6;
  localparam int HI_LIMIT  = 16 * DEC_BASE;  // 0xA0
  localparam int HI_ADJ    = 16 * LO_ADJ;    // 0x60
endpackage

// File: rtl/bcd_units_stage.sv
module bcd_units_stage
  import bcd_pkg::*;
(
  input  logic             op_sub,
  input  logic             x_in,
  input  logic [NIB_W-1:0] acc_lo,
  input  logic [NIB_W-1:0] opd_lo,
  output logic             fix_lo
);
  localparam logic [LO_W-1:0] LO_LIMIT = LO_W'(DEC_BASE);

  logic [LO_W-1:0] a_ext, b_ext, c_ext, lo_val;

  always_comb begin
    a_ext = {2'b00, acc_lo};
    b_ext = {2'b00, opd_lo};
    c_ext = {{(LO_W-1){1'b0}}, x_in};
    if (op_sub) begin
      lo_val = a_ext - b_ext - c_ext;
      fix_lo = lo_val[LO_W-1];          // units went negative
    end else begin
      lo_val = a_ext + b_ext + c_ext;
      fix_lo = (lo_val >= LO_LIMIT);    // units reached ten
    end
  end
endmodule

// File: rtl/bcd_tens_stage.sv
module bcd_tens_stage
  import bcd_pkg::*;
(
  input  logic              op_sub,
  input  logic              x_in,
  input  logic              fix_lo,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] opd,
  output logic [BYTE_W-1:0] res,
  output logic              carry
);
  localparam logic [WIDE_W-1:0] W_LO_ADJ   = WIDE_W'(LO_ADJ);
  localparam logic [WIDE_W-1:0] W_HI_LIMIT = WIDE_W'(HI_LIMIT);
  localparam logic [BYTE_W-1:0] B_HI_ADJ   = BYTE_W'(HI_ADJ);

  logic [WIDE_W-1:0] a_ext, b_ext, c_ext, u_adj, wide;

  always_comb begin
    a_ext = {2'b00, acc};
    b_ext = {2'b00, opd};
    c_ext = {{(WIDE_W-1){1'b0}}, x_in};
    u_adj = fix_lo ? W_LO_ADJ : '0;
    if (op_sub) begin
      wide  = a_ext - b_ext - c_ext - u_adj;
      carry = wide[WIDE_W-1];               // overall borrow
      res   = carry ? (wide[BYTE_W-1:0] - B_HI_ADJ) : wide[BYTE_W-1:0];
    end else begin
      wide  = a_ext + b_ext + c_ext + u_adj;
      carry = (wide >= W_HI_LIMIT);         // tens out of range
      res   = carry ? (wide[BYTE_W-1:0] + B_HI_ADJ) : wide[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/bcd_result_reg.sv
module bcd_result_reg
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] res_d,
  input  logic              carry_d,
  input  logic              z_in,
  output logic              vld_q,
  output logic [BYTE_W-1:0] res_q,
  output logic              carry_q,
  output logic              z_q
);
  logic z_d;

  always_comb z_d = (res_d != '0) ? 1'b0 : z_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      carry_q <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        res_q   <= res_d;
        carry_q <= carry_d;
        z_q     <= z_d;
      end
    end
  end
endmodule

// File: rtl/bcd_byte_addsub.sv
module bcd_byte_addsub
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] opd_in,
  input  logic              x_in,
  input  logic              z_in,
  output logic              res_valid,
  output logic [BYTE_W-1:0] result,
  output logic              cx_out,
  output logic              z_out
);
  logic              fix_lo;
  logic [BYTE_W-1:0] res_c;
  logic              carry_c;

  bcd_units_stage u_units (
    .op_sub (op_sub),
    .x_in   (x_in),
    .acc_lo (acc_in[NIB_W-1:0]),
    .opd_lo (opd_in[NIB_W-1:0]),
    .fix_lo (fix_lo)
  );

  bcd_tens_stage u_tens (
    .op_sub (op_sub),
    .x_in   (x_in),
    .fix_lo (fix_lo),
    .acc    (acc_in),
    .opd    (opd_in),
    .res    (res_c),
    .carry  (carry_c)
  );

  bcd_result_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .res_d   (res_c),
    .carry_d (carry_c),
    .z_in    (z_in),
    .vld_q   (res_valid),
    .res_q   (result),
    .carry_q (cx_out),
    .z_q     (z_out)
  );
endmodule

// File: rtl/bcd_byte_addsub_chk.sv
module bcd_byte_addsub_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       op_sub,
  input logic [7:0] acc_in,
  input logic [7:0] opd_in,
  input logic       x_in,
  input logic       z_in,
  input logic       res_valid,
  input logic [7:0] result,
  input logic       cx_out,
  input logic       z_out
);
  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(result) && $stable(cx_out) && $stable(z_out)));
  // R7
  z_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && result != 8'h00) |-> !z_out);
  // R7
  z_never_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !z_in) |=> !z_out);
  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sub && ({1'b0, acc_in} + {1'b0, opd_in} + {8'h00, x_in}) >= 9'h0A0)
      |=> cx_out);
  // R5
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sub && ({1'b0, acc_in} < ({1'b0, opd_in} + {8'h00, x_in})))
      |=> cx_out);
  // R10
  bcd_digits_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_in[3:0] <= 4'd9 && acc_in[7:4] <= 4'd9 &&
     opd_in[3:0] <= 4'd9 && opd_in[7:4] <= 4'd9)
      |=> (result[3:0] <= 4'd9 && result[7:4] <= 4'd9));
endmodule

bind bcd_byte_addsub bcd_byte_addsub_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sub    (op_sub),
  .acc_in    (acc_in),
  .opd_in    (opd_in),
  .x_in      (x_in),
  .z_in      (z_in),
  .res_valid (res_valid),
  .result    (result),
  .cx_out    (cx_out),
  .z_out     (z_out)
);

// File: tb/tb_bcd_byte_addsub.sv
`timescale 1ns/1ps
module tb_bcd_byte_addsub;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       op_sub = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opd_in = 8'h00;
  logic       x_in = 1'b0;
  logic       z_in = 1'b0;
  logic       res_valid;
  logic [7:0] result;
  logic       cx_out;
  logic       z_out;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  bcd_byte_addsub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .acc_in(acc_in), .opd_in(opd_in), .x_in(x_in), .z_in(z_in),
    .res_valid(res_valid), .result(result), .cx_out(cx_out), .z_out(z_out)
  );

  // {sub, x, z_in, acc, opd, exp_result, exp_cx, exp_z}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0}, // R2 no carry
    {1'b0, 1'b0, 1'b0, 8'h15, 8'h27, 8'h42, 1'b0, 1'b0}, // R1 units fix
    {1'b0, 1'b1, 1'b1, 8'h45, 8'h54, 8'h00, 1'b1, 1'b1}, // R1 R2 R3 R7
    {1'b0, 1'b1, 1'b0, 8'h99, 8'h99, 8'h99, 1'b1, 1'b0}, // R2 R3
    {1'b0, 1'b0, 1'b0, 8'h50, 8'h50, 8'h00, 1'b1, 1'b0}, // R2 R7
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0}, // R3 R7
    {1'b0, 1'b1, 1'b1, 8'h08, 8'h01, 8'h10, 1'b0, 1'b0}, // R1 R3
    {1'b1, 1'b0, 1'b1, 8'h46, 8'h12, 8'h34, 1'b0, 1'b0}, // R5 no borrow
    {1'b1, 1'b0, 1'b0, 8'h42, 8'h15, 8'h27, 1'b0, 1'b0}, // R4
    {1'b1, 1'b0, 1'b0, 8'h12, 8'h34, 8'h78, 1'b1, 1'b0}, // R4 R5
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h99, 1'b1, 1'b0}, // R5 R6
    {1'b1, 1'b1, 1'b1, 8'h50, 8'h49, 8'h00, 1'b0, 1'b1}, // R4 R6 R7
    {1'b1, 1'b0, 1'b0, 8'h25, 8'h25, 8'h00, 1'b0, 1'b0}, // R7
    {1'b1, 1'b0, 1'b1, 8'h30, 8'h05, 8'h25, 1'b0, 1'b0}  // R4
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held_r;
    logic       held_c, held_z;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 res_valid", {7'd0, res_valid}, 8'h00);
    chk("R9 result", result, 8'h00);
    chk("R9 cx_out", {7'd0, cx_out}, 8'h00);
    chk("R9 z_out", {7'd0, z_out}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op_sub   = VEC[i][28];
      x_in     = VEC[i][27];
      z_in     = VEC[i][26];
      acc_in   = VEC[i][25:18];
      opd_in   = VEC[i][17:10];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R8 vec%0d res_valid", i), {7'd0, res_valid}, 8'h01);
      chk($sformatf("R1-5 vec%0d result (R1 R2 R3 R4 R5 R6)", i), result, VEC[i][9:2]);
      chk($sformatf("R2/R5 vec%0d cx_out", i), {7'd0, cx_out}, {7'd0, VEC[i][1]});
      chk($sformatf("R7 vec%0d z_out", i), {7'd0, z_out}, {7'd0, VEC[i][0]});
    end

    // R8: idle cycles with changed inputs leave outputs untouched
    held_r = result; held_c = cx_out; held_z = z_out;
    in_valid = 1'b0;
    op_sub = 1'b0; acc_in = 8'h55; opd_in = 8'h55; x_in = 1'b1; z_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 idle res_valid", {7'd0, res_valid}, 8'h00);
    chk("R8 idle result", result, held_r);
    chk("R8 idle cx_out", {7'd0, cx_out}, {7'd0, held_c});
    chk("R8 idle z_out", {7'd0, z_out}, {7'd0, held_z});

    // R8: single pulse then gap
    in_valid = 1'b1; op_sub = 1'b0; acc_in = 8'h09; opd_in = 8'h09; x_in = 1'b0; z_in = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 pulse result", result, 8'h18);
    @(negedge clk);
    chk("R8 pulse drop res_valid", {7'd0, res_valid}, 8'h00);
    chk("R8 pulse hold result", result, 8'h18);

    // R9: reset in mid-run clears outputs
    in_valid = 1'b1; op_sub = 1'b1; acc_in = 8'h00; opd_in = 8'h01; x_in = 1'b0;
    @(negedge clk);
    chk("R5 pre-reset cx_out", {7'd0, cx_out}, 8'h01);
    chk("R5 pre-reset result", result, 8'h99);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 mid result", result, 8'h00);
    chk("R9 mid cx_out", {7'd0, cx_out}, 8'h00);
    chk("R9 mid res_valid", {7'd0, res_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule